// File: doc/BRIEF.md
# Video-Mode Panel Timing Generator

This block produces the sync and framing signals for a panel that is driven in video mode. One counter runs across each line in pixel clocks. A second counter runs across the whole frame, also in pixel clocks. Every vertical quantity is a pixel-clock offset from the start of the frame: the sync pulse length, the display window bounds and the active window bounds. The vertical bounds can therefore begin or end partway through a line. A skew value moves the start of the vertical display window by a number of pixel clocks, so the start can be placed below line granularity.

From the two counters the block decodes the following:
- horizontal sync, vertical sync and data enable, each with its own polarity control;
- an active-window flag, which marks where fetched pixels belong;
- a one-clock frame-start pulse;
- a pixel-select code that tells the downstream mux to use the fetched pixel, a border fill, an underflow fill or blanking.

The matching fill colour is driven beside the select code. A starvation input from the pixel feeder switches the output to the underflow colour. If recovery is enabled, normal pixels return at the next line start. If it is not, the underflow colour holds to the end of the frame. Software programs all bounds as plain pixel-clock values. Deasserting the enable stops the timing, and asserting it again restarts the frame at position zero.

Top module: `vidtiming_gen`

## Requirements
- R1: While `en` is low, and after reset, the block is idle. In the idle state `active` and `frame_start` are 0, `pix_sel` is 3 (blank), and each of hsync, vsync and de shows its inactive level. The inactive level is 0 when its polarity bit is clear and 1 when it is set.
- R2: The first clock edge that samples `en` high starts the timing at line position 0 and frame position 0. That cycle is frame position n=0. `frame_start` is 1 in exactly the cycles where the frame position is 0. Dropping `en` and raising it again restarts the frame at position 0.
- R3: The line position counts from 0 to `h_period`-1 and then wraps to 0. The line position is also cleared whenever the frame wraps. The uninverted hsync is high while the line position is below `h_pulse`.
- R4: The frame position counts pixel clocks from 0 to `v_period`-1 and then wraps. The uninverted vsync is high while the frame position is below `v_pulse`.
- R5: The uninverted data enable is high only when both of these hold:
  - the line position is in the closed range [`disp_hs`, `disp_he`];
  - the frame position is in the half-open range [`disp_vs` + `hs_skew`, `disp_ve`).
- R6: `active` is high when data enable is high and both window tests pass:
  - Horizontal test: when `act_x_en` is 1, the line position must be within [`act_hs`, `act_he`] inclusive. When `act_x_en` is 0, the horizontal display range is used.
  - Vertical test: when `act_y_en` is 1, the frame position must be within [`act_vs`, `act_ve`] inclusive. When `act_y_en` is 0, the vertical display range is used.
- R7: Setting `polarity` bit 0 inverts hsync. Setting bit 1 inverts vsync. Setting bit 2 inverts de.
- R8: `pix_sel` encodes the pixel source as follows: 0 = fetched, 1 = border, 2 = underflow, 3 = blank.
  - Outside data enable it is blank.
  - Inside data enable it is underflow while an underflow is shown, otherwise border outside the active window, otherwise fetched.
  - `fill_color` is `uflow_color` while underflow is shown, and `border_color` otherwise.
- R9: An underflow starts in a cycle where `starved` is high and `active` is high, and is shown from that cycle. With `uflow_recover` set, it is shown through the remaining data-enable pixels of that line, and the next line starts with normal pixel selection.
- R10: With `uflow_recover` clear, an underflow is shown on every data-enable pixel until the end of the frame, and the next frame starts normally.
- R11: `starved` has no effect in a cycle where `active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timing enable |
| h_period | input | HW | Line length in pixel clocks |
| h_pulse | input | HW | Hsync pulse length |
| v_period | input | FW | Frame length in pixel clocks |
| v_pulse | input | FW | Vsync pulse length in pixel clocks |
| disp_hs | input | HW | First display pixel of a line |
| disp_he | input | HW | Last display pixel of a line |
| disp_vs | input | FW | Display start in frame pixel clocks, before skew |
| disp_ve | input | FW | Display end in frame pixel clocks, exclusive |
| hs_skew | input | HW | Pixel-clock offset added to the display start |
| act_x_en | input | 1 | Use the horizontal active bounds |
| act_hs | input | HW | First active pixel of a line |
| act_he | input | HW | Last active pixel of a line |
| act_y_en | input | 1 | Use the vertical active bounds |
| act_vs | input | FW | First active frame position |
| act_ve | input | FW | Last active frame position |
| border_color | input | CW | Fill colour for the border area |
| uflow_color | input | CW | Fill colour while starved |
| uflow_recover | input | 1 | Resume at the next line after underflow |
| polarity | input | 3 | Inversion bits: 0 hsync, 1 vsync, 2 de |
| starved | input | 1 | The pixel feeder has no data this cycle |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| active | output | 1 | Inside the active window |
| frame_start | output | 1 | One-clock pulse at frame position 0 |
| pix_sel | output | 2 | Pixel source select |
| fill_color | output | CW | Border or underflow colour |

## Verification
The hardest state to reach from the ports is an underflow that is still latched when the line or frame boundary clears it. The starvation must begin on an active pixel, and the following border pixels of that line must still show the underflow colour. The bench drives a single-cycle `starved` pulse at a chosen active position and then sweeps every cycle to the end of the frame and past it. It checks both settings of `uflow_recover`. It also places a pulse on a border pixel to confirm that the pulse is ignored. A frame whose display start is shifted by a nonzero skew, with one active-window enable cleared, covers the pixel-granular vertical bounds.

// File: rtl/vidtiming_pkg.sv
package vidtiming_pkg;

    typedef enum logic [1:0] {
        SEL_FETCH  = 2'd0,
        SEL_BORDER = 2'd1,
        SEL_UFLOW  = 2'd2,
        SEL_BLANK  = 2'd3
    } pix_sel_e;

    localparam int POL_BITS = 3;
    localparam int POL_HS   = 0;
    localparam int POL_VS   = 1;
    localparam int POL_DE   = 2;

    // Uninverted timing flags decoded from the counters.
    typedef struct packed {
        logic act;
        logic de;
        logic vs;
        logic hs;
    } raw_sync_t;

    function automatic logic in_closed32(input logic [31:0] v, input logic [31:0] lo,
                                         input logic [31:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/vidtiming_counters.sv
module vidtiming_counters #(
    parameter int HW = 16,
    parameter int FW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [HW-1:0] h_period,
    input  logic [FW-1:0] v_period,
    output logic          run,
    output logic [HW-1:0] hcnt,
    output logic [FW-1:0] fcnt,
    output logic          line_end,
    output logic          frame_end
);
    localparam logic [HW-1:0] H_ONE = HW'(1);
    localparam logic [FW-1:0] F_ONE = FW'(1);

    assign line_end  = (hcnt == h_period - H_ONE);
    assign frame_end = (fcnt == v_period - F_ONE);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run  <= 1'b0;
            hcnt <= '0;
            fcnt <= '0;
        end else begin
            run <= 1'b1;
            if (run) begin
                if (frame_end) begin
                    hcnt <= '0;
                    fcnt <= '0;
                end else begin
                    fcnt <= fcnt + F_ONE;
                    hcnt <= line_end ? '0 : hcnt + H_ONE;
                end
            end
        end
    end

    p_hcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (run && h_period != '0) |-> (hcnt < h_period));

    p_restart_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (hcnt == '0 && fcnt == '0));

    p_frame_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(fcnt) == $past(v_period) - F_ONE) |-> (fcnt == '0));

endmodule

// File: rtl/vidtiming_window.sv
module vidtiming_window
    import vidtiming_pkg::*;
#(
    parameter int HW = 16,
    parameter int FW = 32
) (
    input  logic          run,
    input  logic [HW-1:0] hcnt,
    input  logic [FW-1:0] fcnt,
    input  logic [HW-1:0] h_pulse,
    input  logic [FW-1:0] v_pulse,
    input  logic [HW-1:0] disp_hs,
    input  logic [HW-1:0] disp_he,
    input  logic [FW-1:0] disp_vs,
    input  logic [FW-1:0] disp_ve,
    input  logic [HW-1:0] hs_skew,
    input  logic          act_x_en,
    input  logic [HW-1:0] act_hs,
    input  logic [HW-1:0] act_he,
    input  logic          act_y_en,
    input  logic [FW-1:0] act_vs,
    input  logic [FW-1:0] act_ve,
    output raw_sync_t     raw
);
    logic [FW-1:0] vs_eff;
    logic disp_h, disp_v, act_h, act_v;

    // Skew shifts the display start by whole pixel clocks.
    assign vs_eff = disp_vs + FW'(hs_skew);

    always_comb begin
        disp_h = in_closed32(32'(hcnt), 32'(disp_hs), 32'(disp_he));
        disp_v = (fcnt >= vs_eff) && (fcnt < disp_ve);
        act_h  = act_x_en ? in_closed32(32'(hcnt), 32'(act_hs), 32'(act_he)) : disp_h;
        act_v  = act_y_en ? in_closed32(32'(fcnt), 32'(act_vs), 32'(act_ve)) : disp_v;
        raw.hs  = run && (hcnt < h_pulse);
        raw.vs  = run && (fcnt < v_pulse);
        raw.de  = run && disp_h && disp_v;
        raw.act = run && disp_h && disp_v && act_h && act_v;
    end

endmodule

// File: rtl/vidtiming_pixsel.sv
module vidtiming_pixsel
    import vidtiming_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          line_end,
    input  logic          frame_end,
    input  raw_sync_t     raw,
    input  logic          starved,
    input  logic          uflow_recover,
    input  logic [CW-1:0] border_color,
    input  logic [CW-1:0] uflow_color,
    output pix_sel_e      sel,
    output logic [CW-1:0] fill
);
    logic uflow_q, uflow_now, show_uflow, clear_evt;

    assign uflow_now  = raw.act && starved;
    assign show_uflow = raw.de && (uflow_q || uflow_now);
    assign clear_evt  = frame_end || (uflow_recover && line_end);

    always_ff @(posedge clk) begin
        if (rst || !run)       uflow_q <= 1'b0;
        else if (clear_evt)    uflow_q <= 1'b0;
        else if (uflow_now)    uflow_q <= 1'b1;
    end

    always_comb begin
        if (!raw.de)         sel = SEL_BLANK;
        else if (show_uflow) sel = SEL_UFLOW;
        else if (!raw.act)   sel = SEL_BORDER;
        else                 sel = SEL_FETCH;
        fill = show_uflow ? uflow_color : border_color;
    end

    p_uflow_line_resume_r9: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(uflow_recover) && $past(line_end)) |-> !uflow_q);

    p_uflow_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(uflow_q) && !$past(uflow_recover) && !$past(frame_end))
        |-> uflow_q);

endmodule

// File: rtl/vidtiming_gen.sv
module vidtiming_gen
    import vidtiming_pkg::*;
#(
    parameter int HW = 16,
    parameter int FW = 32,
    parameter int CW = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [HW-1:0]       h_period,
    input  logic [HW-1:0]       h_pulse,
    input  logic [FW-1:0]       v_period,
    input  logic [FW-1:0]       v_pulse,
    input  logic [HW-1:0]       disp_hs,
    input  logic [HW-1:0]       disp_he,
    input  logic [FW-1:0]       disp_vs,
    input  logic [FW-1:0]       disp_ve,
    input  logic [HW-1:0]       hs_skew,
    input  logic                act_x_en,
    input  logic [HW-1:0]       act_hs,
    input  logic [HW-1:0]       act_he,
    input  logic                act_y_en,
    input  logic [FW-1:0]       act_vs,
    input  logic [FW-1:0]       act_ve,
    input  logic [CW-1:0]       border_color,
    input  logic [CW-1:0]       uflow_color,
    input  logic                uflow_recover,
    input  logic [POL_BITS-1:0] polarity,
    input  logic                starved,
    output logic                hsync,
    output logic                vsync,
    output logic                de,
    output logic                active,
    output logic                frame_start,
    output logic [1:0]          pix_sel,
    output logic [CW-1:0]       fill_color
);
    logic          run, line_end, frame_end;
    logic [HW-1:0] hcnt;
    logic [FW-1:0] fcnt;
    raw_sync_t     raw;
    pix_sel_e      sel;
    logic [POL_BITS-1:0] sync_raw, sync_out;

    vidtiming_counters #(.HW(HW), .FW(FW)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .h_period(h_period), .v_period(v_period),
        .run(run), .hcnt(hcnt), .fcnt(fcnt), .line_end(line_end), .frame_end(frame_end)
    );

    vidtiming_window #(.HW(HW), .FW(FW)) u_win (
        .run(run), .hcnt(hcnt), .fcnt(fcnt), .h_pulse(h_pulse), .v_pulse(v_pulse),
        .disp_hs(disp_hs), .disp_he(disp_he), .disp_vs(disp_vs), .disp_ve(disp_ve),
        .hs_skew(hs_skew), .act_x_en(act_x_en), .act_hs(act_hs), .act_he(act_he),
        .act_y_en(act_y_en), .act_vs(act_vs), .act_ve(act_ve), .raw(raw)
    );

    vidtiming_pixsel #(.CW(CW)) u_sel (
        .clk(clk), .rst(rst), .run(run), .line_end(line_end), .frame_end(frame_end),
        .raw(raw), .starved(starved), .uflow_recover(uflow_recover),
        .border_color(border_color), .uflow_color(uflow_color), .sel(sel), .fill(fill_color)
    );

    always_comb begin
        sync_raw         = '0;
        sync_raw[POL_HS] = raw.hs;
        sync_raw[POL_VS] = raw.vs;
        sync_raw[POL_DE] = raw.de;
    end

    for (genvar i = 0; i < POL_BITS; i++) begin : g_pol
        assign sync_out[i] = sync_raw[i] ^ polarity[i];
    end

    assign hsync       = sync_out[POL_HS];
    assign vsync       = sync_out[POL_VS];
    assign de          = sync_out[POL_DE];
    assign active      = raw.act;
    assign frame_start = run && (fcnt == '0);
    assign pix_sel     = sel;

    p_idle_blank_r1: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pix_sel == 2'd3 && !frame_start && !active));

    p_active_in_de_r6: assert property (@(posedge clk) disable iff (rst)
        active |-> (de != polarity[POL_DE]));

endmodule

// File: tb/vidtiming_gen_bench.sv
`timescale 1ns/1ps
module vidtiming_gen_bench;
    localparam int HW = 16, FW = 32, CW = 24;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, en, starved;
    int c_hp, c_hpw, c_vp, c_vpw, c_dhs, c_dhe, c_dvs, c_dve, c_sk;
    int c_ahs, c_ahe, c_avs, c_ave;
    logic c_xen, c_yen, c_rec;
    logic [2:0] c_pol;
    localparam logic [CW-1:0] BORDER = 24'hA5A5A5;
    localparam logic [CW-1:0] UCOL   = 24'h123456;

    logic hsync, vsync, de, active, frame_start;
    logic [1:0] pix_sel;
    logic [CW-1:0] fill_color;

    vidtiming_gen #(.HW(HW), .FW(FW), .CW(CW)) u_vidtiming_gen (
        .clk(clk), .rst(rst), .en(en),
        .h_period(HW'(c_hp)), .h_pulse(HW'(c_hpw)), .v_period(FW'(c_vp)), .v_pulse(FW'(c_vpw)),
        .disp_hs(HW'(c_dhs)), .disp_he(HW'(c_dhe)), .disp_vs(FW'(c_dvs)), .disp_ve(FW'(c_dve)),
        .hs_skew(HW'(c_sk)), .act_x_en(c_xen), .act_hs(HW'(c_ahs)), .act_he(HW'(c_ahe)),
        .act_y_en(c_yen), .act_vs(FW'(c_avs)), .act_ve(FW'(c_ave)),
        .border_color(BORDER), .uflow_color(UCOL), .uflow_recover(c_rec),
        .polarity(c_pol), .starved(starved),
        .hsync(hsync), .vsync(vsync), .de(de), .active(active), .frame_start(frame_start),
        .pix_sel(pix_sel), .fill_color(fill_color)
    );

    int checks = 0, fails = 0, starve_n = -1;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_de(int n);
        int h = n % c_hp, f = n % c_vp;
        return (h >= c_dhs && h <= c_dhe) && (f >= c_dvs + c_sk && f < c_dve);
    endfunction

    function automatic bit m_act(int n);
        int h = n % c_hp, f = n % c_vp;
        bit ah = c_xen ? (h >= c_ahs && h <= c_ahe) : (h >= c_dhs && h <= c_dhe);
        bit av = c_yen ? (f >= c_avs && f <= c_ave) : (f >= c_dvs + c_sk && f < c_dve);
        return m_de(n) && ah && av;
    endfunction

    task automatic check_pos(input string scen, input int n);
        int h = n % c_hp, f = n % c_vp;
        bit uf, ede, eact;
        logic [1:0] esel;
        ede  = m_de(n);
        eact = m_act(n);
        uf   = (starve_n >= 0) && m_act(starve_n) && n >= starve_n &&
               (c_rec ? (n / c_hp == starve_n / c_hp) : (n / c_vp == starve_n / c_vp));
        esel = !ede ? 2'd3 : (uf ? 2'd2 : (!eact ? 2'd1 : 2'd0));
        chk($sformatf("%s n=%0d hsync R3", scen, n), 32'(hsync), 32'((h < c_hpw) ^ c_pol[0]));
        chk($sformatf("%s n=%0d vsync R4", scen, n), 32'(vsync), 32'((f < c_vpw) ^ c_pol[1]));
        chk($sformatf("%s n=%0d de R5", scen, n), 32'(de), 32'(ede ^ c_pol[2]));
        chk($sformatf("%s n=%0d active R6", scen, n), 32'(active), 32'(eact));
        chk($sformatf("%s n=%0d frame_start R2", scen, n), 32'(frame_start), 32'(f == 0));
        chk($sformatf("%s n=%0d pix_sel R8", scen, n), 32'(pix_sel), 32'(esel));
        if (esel == 2'd1 || esel == 2'd2)
            chk($sformatf("%s n=%0d fill R8", scen, n), 32'(fill_color),
                32'(esel == 2'd2 ? UCOL : BORDER));
    endtask

    task automatic check_idle(input string scen);
        chk({scen, " hsync idle R1"}, 32'(hsync), 32'(c_pol[0]));
        chk({scen, " vsync idle R1"}, 32'(vsync), 32'(c_pol[1]));
        chk({scen, " de idle R1"}, 32'(de), 32'(c_pol[2]));
        chk({scen, " active idle R1"}, 32'(active), 32'd0);
        chk({scen, " frame_start idle R1"}, 32'(frame_start), 32'd0);
        chk({scen, " pix_sel idle R1"}, 32'(pix_sel), 32'd3);
    endtask

    // Enables the timing and checks positions 0..cycles-1; cycles<0 leaves it running.
    task automatic run_span(input string scen, input int cycles);
        @(posedge clk); #2 en = 1'b1;
        for (int n = 0; n < cycles; n++) begin
            @(posedge clk); #2 starved = (n == starve_n);
            #1 check_pos(scen, n);
        end
        #1 starved = 1'b0;
    endtask

    task automatic stop_timing(input string scen);
        @(posedge clk); #2 en = 1'b0; starved = 1'b0;
        @(posedge clk); #3 check_idle(scen);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; starved = 1'b0;
        // 10-clock lines, 7 lines per frame, 5 display pixels, 3 display lines.
        c_hp = 10; c_hpw = 2; c_vp = 70; c_vpw = 10;
        c_dhs = 3; c_dhe = 7; c_dvs = 20; c_dve = 50; c_sk = 0;
        c_xen = 1; c_ahs = 4; c_ahe = 6; c_yen = 1; c_avs = 30; c_ave = 49;
        c_rec = 1; c_pol = 3'b000;
        repeat (3) @(posedge clk);
        #3 check_idle("reset pol0");
        c_pol = 3'b111;
        #1 check_idle("reset pol111 R7");
        c_pol = 3'b000;
        @(posedge clk); #2 rst = 1'b0;

        run_span("base R2", 140);
        stop_timing("disable R1");

        run_span("restart-a R2", 25);
        stop_timing("midframe stop R1");
        run_span("restart-b R2", 70);
        stop_timing("after restart");

        c_sk = 3; c_pol = 3'b101; c_xen = 0;
        run_span("skew pol R7", 140);
        stop_timing("skew idle R7");
        c_sk = 0; c_pol = 3'b000; c_xen = 1;

        c_rec = 1; starve_n = 35;
        run_span("uflow recover R9", 140);
        stop_timing("uflow recover idle");

        c_rec = 0; starve_n = 35;
        run_span("uflow sticky R10", 140);
        stop_timing("uflow sticky idle");

        c_rec = 0; starve_n = 33;
        run_span("starve border R11", 70);
        stop_timing("starve border idle");
        starve_n = 5;
        run_span("starve blank R11", 70);
        stop_timing("starve blank idle");
        starve_n = -1;

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule